// File: doc/BRIEF.md
# Serial Transmitter/Receiver with Line-Override Break Control

This unit combines a byte-wide serial transmitter, an oversampling receiver and an output selector for the transmit pin. While the transmitter is enabled, the pin carries the serial stream. While it is disabled, the pin falls back to a software-held direction bit and level bit. Software produces a break by driving that level bit low and then switching the transmitter off. Switching the transmitter off aborts any frame in progress at once.

Every bit period is counted on a base tick input that pulses sixteen times per bit. The transmitter has two framings. In the asynchronous framing, frames are start-marked, with optional even parity. In the clocked framing, only the data bits are sent, alongside a bit clock. In the clocked framing, a new byte is held back while any receive error flag is pending. The receiver is asynchronous. It locks onto a high-to-low transition seen on a tick, and it samples each bit once, on a fixed tick within the bit.

Top module: `sio_break_unit`

## Requirements
- R1: While `tx_enable` is 0, `ser_oe` equals `pin_dir` and `ser_out` equals `pin_level`, in the same cycle.
- R2: While `tx_enable` is 1, `ser_oe` is 1, and `ser_out` is 1 whenever no frame is being shifted.
- R3: A cycle with `tx_enable` at 0 returns the transmitter to idle and empties the holding register (`tx_empty` is 1 in the next cycle), even mid-frame. With `pin_dir`=1 and `pin_level`=0 the line then stays at 0 (break).
- R4: A `tx_write` pulse while enabled and `tx_empty` is 1 stores `tx_data` and clears `tx_empty` in the next cycle. A write while full is ignored. `tx_empty` returns to 1 in the cycle a frame begins.
- R5: In the asynchronous framing (`sync_mode`=0), a frame is sent bit 0 first, each bit lasting 16 base ticks: a 0, then the eight data bits from LSB to MSB, then (if `par_en`=1) the XOR of the data bits, then a 1.
- R6: In the clocked framing (`sync_mode`=1), only the eight data bits are sent, LSB first, 16 ticks each. During a frame, `ser_clk` is 0 for ticks 0-7 of each bit and 1 for ticks 8-15. At all other times it is 1.
- R7: With `sync_mode`=1, a stored byte does not start while any of `err_overrun`, `err_parity` or `err_framing` is 1. It starts once all three are 0.
- R8: With `rx_enable`=1, a tick on which `ser_in` is 0 after being 1 on the previous tick is tick 0 of the start bit. Bit k is sampled on tick 16k+7 only. Bits 1-8 are the data, LSB first.
- R9: If `ser_in` is 1 at the start-bit sample, reception is abandoned and nothing is stored.
- R10: At the stop sample, the byte is stored in `rx_data` and `rx_full` is set. `err_parity` is set when `par_en`=1 and the received parity bit differs from the XOR of the data. `err_framing` is set when the stop sample is 0.
- R11: If a frame completes while `rx_full` is 1, `err_overrun` is set and `rx_data` keeps the unread byte. `rx_ack` clears `rx_full`.
- R12: Error flags are sticky. Clearing `rx_enable` leaves them set. Each flag is cleared only by its own clear strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| tx_enable | input | 1 | Transmitter enable |
| rx_enable | input | 1 | Receiver enable |
| sync_mode | input | 1 | 1 selects the clocked framing for transmit |
| par_en | input | 1 | Adds an even parity bit to asynchronous frames |
| pin_dir | input | 1 | Fallback pin direction, 1 = output |
| pin_level | input | 1 | Fallback pin level |
| tx_write | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Holding register empty |
| ser_in | input | 1 | Receive line, already synchronous to clk |
| rx_ack | input | 1 | Marks the received byte as read |
| clr_overrun | input | 1 | Clears err_overrun |
| clr_parity | input | 1 | Clears err_parity |
| clr_framing | input | 1 | Clears err_framing |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Unread byte present |
| err_overrun | output | 1 | Overrun flag |
| err_parity | output | 1 | Parity error flag |
| err_framing | output | 1 | Framing error flag |
| ser_out | output | 1 | Transmit pin level |
| ser_oe | output | 1 | Transmit pin output enable |
| ser_clk | output | 1 | Bit clock in the clocked framing |

## Verification
The properties assume that the strobes are one-cycle pulses and that `ser_in` is already synchronous. They also assume that `sync_mode` and `par_en` change only while no frame is in flight, because the frame layout is fixed when a frame starts. The stimulus changes every input half a cycle away from the active edge. It toggles the framing controls only after the reference model reports the transmitter idle. Receive frames are driven tick by tick from the base tick. In one variant, each bit holds its true value only on its sample tick, so a sampling point off by a single tick corrupts the byte.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int DEF_DATA_W     = 8;
    localparam int DEF_OVERSAMPLE = 16;

    typedef enum logic {
        PH_IDLE,
        PH_RUN
    } phase_e;

    typedef struct packed {
        logic ovr;
        logic par;
        logic frm;
    } rx_err_t;

    // number of bit slots in one transmitted frame
    function automatic int tx_frame_bits(input logic sync, input logic par, input int dw);
        if (sync) return dw;
        return dw + 2 + (par ? 1 : 0);
    endfunction

    // bit slot that carries the stop bit on the receive side
    function automatic int rx_stop_index(input logic par, input int dw);
        return dw + 1 + (par ? 1 : 0);
    endfunction

endpackage

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int OVERSAMPLE = DEF_OVERSAMPLE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              tx_en,
    input  logic              sync_mode,
    input  logic              par_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              err_pend,
    output logic              line_o,
    output logic              sck_o,
    output logic              hold_empty_o
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(OVERSAMPLE);
    localparam int IDX_W   = $clog2(FRAME_W + 1);
    localparam int HALF    = OVERSAMPLE / 2;

    phase_e             phase;
    logic [DATA_W-1:0]  hold_q;
    logic               hold_full;
    logic [FRAME_W-1:0] shift_q;
    logic [CNT_W-1:0]   tcnt;
    logic [IDX_W-1:0]   bidx;
    logic [IDX_W-1:0]   last_idx;

    logic [FRAME_W-1:0] frame_d;
    logic [IDX_W-1:0]   last_d;
    logic               start_ok;
    logic               bit_end;

    always_comb begin
        frame_d = '1;
        if (sync_mode) begin
            frame_d[DATA_W-1:0] = hold_q;
        end else begin
            frame_d[0]        = 1'b0;
            frame_d[DATA_W:1] = hold_q;
            if (par_en) frame_d[DATA_W+1] = ^hold_q;
        end
        last_d = IDX_W'(tx_frame_bits(sync_mode, par_en, DATA_W) - 1);
    end

    // clocked framing: a pending receive error holds the byte back
    assign start_ok = (phase == PH_IDLE) && hold_full && !(sync_mode && err_pend);
    assign bit_end  = (phase == PH_RUN) && tick && (tcnt == CNT_W'(OVERSAMPLE - 1));

    always_ff @(posedge clk) begin
        if (rst || !tx_en) begin
            phase     <= PH_IDLE;
            hold_q    <= '0;
            hold_full <= 1'b0;
            shift_q   <= '1;
            tcnt      <= '0;
            bidx      <= '0;
            last_idx  <= '0;
        end else begin
            if (wr_stb && !hold_full) begin
                hold_q    <= wr_data;
                hold_full <= 1'b1;
            end
            if (start_ok) begin
                shift_q   <= frame_d;
                last_idx  <= last_d;
                bidx      <= '0;
                tcnt      <= '0;
                phase     <= PH_RUN;
                hold_full <= 1'b0;
            end else if (phase == PH_RUN && tick) begin
                if (bit_end) begin
                    tcnt <= '0;
                    if (bidx == last_idx) begin
                        phase <= PH_IDLE;
                    end else begin
                        bidx    <= bidx + 1'b1;
                        shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

    assign line_o       = (phase == PH_RUN) ? shift_q[0] : 1'b1;
    assign sck_o        = (phase == PH_RUN && sync_mode) ? (tcnt >= CNT_W'(HALF)) : 1'b1;
    assign hold_empty_o = !hold_full;

endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int OVERSAMPLE = DEF_OVERSAMPLE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              rxd_i,
    input  logic              rd_ack,
    input  logic              clr_ovr,
    input  logic              clr_par,
    input  logic              clr_frm,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output rx_err_t           err_o
);
    localparam int CNT_W     = $clog2(OVERSAMPLE);
    localparam int IDX_W     = $clog2(DATA_W + 4);
    localparam int SAMPLE_AT = OVERSAMPLE / 2 - 1;

    phase_e            phase;
    logic              prev_q;
    logic [CNT_W-1:0]  tcnt;
    logic [IDX_W-1:0]  bidx;
    logic [DATA_W-1:0] shift_q;
    logic              par_q;
    logic [DATA_W-1:0] data_q;
    logic              full_q;
    rx_err_t           err_q;
    logic [IDX_W-1:0]  stop_idx;

    assign stop_idx = IDX_W'(rx_stop_index(par_en, DATA_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            prev_q  <= 1'b1;
            tcnt    <= '0;
            bidx    <= '0;
            shift_q <= '0;
            par_q   <= 1'b0;
            data_q  <= '0;
            full_q  <= 1'b0;
            err_q   <= '0;
        end else begin
            if (tick) prev_q <= rxd_i;
            if (rd_ack)  full_q    <= 1'b0;
            if (clr_ovr) err_q.ovr <= 1'b0;
            if (clr_par) err_q.par <= 1'b0;
            if (clr_frm) err_q.frm <= 1'b0;

            if (!rx_en) begin
                phase <= PH_IDLE;
                tcnt  <= '0;
                bidx  <= '0;
            end else if (phase == PH_IDLE) begin
                // the detecting tick counts as tick 0 of the start bit
                if (tick && prev_q && !rxd_i) begin
                    phase <= PH_RUN;
                    tcnt  <= CNT_W'(1);
                    bidx  <= '0;
                end
            end else if (tick) begin
                if (tcnt == CNT_W'(OVERSAMPLE - 1)) begin
                    tcnt <= '0;
                    bidx <= bidx + 1'b1;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
                if (tcnt == CNT_W'(SAMPLE_AT)) begin
                    if (bidx == '0) begin
                        if (rxd_i) phase <= PH_IDLE;
                    end else if (bidx <= IDX_W'(DATA_W)) begin
                        shift_q <= {rxd_i, shift_q[DATA_W-1:1]};
                    end else if (bidx != stop_idx) begin
                        par_q <= rxd_i;
                    end else begin
                        phase <= PH_IDLE;
                        if (full_q) begin
                            err_q.ovr <= 1'b1;
                        end else begin
                            data_q <= shift_q;
                            full_q <= 1'b1;
                            if (par_en && (par_q != ^shift_q)) err_q.par <= 1'b1;
                            if (!rxd_i) err_q.frm <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign data_o = data_q;
    assign full_o = full_q;
    assign err_o  = err_q;

endmodule

// File: rtl/sio_pinmux.sv
module sio_pinmux (
    input  logic tx_en,
    input  logic tx_line,
    input  logic port_dir,
    input  logic port_lvl,
    output logic pin_o,
    output logic pin_oe
);
    always_comb begin
        if (tx_en) begin
            pin_o  = tx_line;
            pin_oe = 1'b1;
        end else begin
            pin_o  = port_lvl;
            pin_oe = port_dir;
        end
    end
endmodule

// File: rtl/sio_break_unit.sv
module sio_break_unit
    import sio_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int OVERSAMPLE = DEF_OVERSAMPLE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_tick,
    input  logic              tx_enable,
    input  logic              rx_enable,
    input  logic              sync_mode,
    input  logic              par_en,
    input  logic              pin_dir,
    input  logic              pin_level,
    input  logic              tx_write,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_empty,
    input  logic              ser_in,
    input  logic              rx_ack,
    input  logic              clr_overrun,
    input  logic              clr_parity,
    input  logic              clr_framing,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              err_overrun,
    output logic              err_parity,
    output logic              err_framing,
    output logic              ser_out,
    output logic              ser_oe,
    output logic              ser_clk
);
    rx_err_t rx_err;
    logic    tx_line;

    sio_tx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_tx (
        .clk          (clk),
        .rst          (rst),
        .tick         (base_tick),
        .tx_en        (tx_enable),
        .sync_mode    (sync_mode),
        .par_en       (par_en),
        .wr_stb       (tx_write),
        .wr_data      (tx_data),
        .err_pend     (|rx_err),
        .line_o       (tx_line),
        .sck_o        (ser_clk),
        .hold_empty_o (tx_empty)
    );

    sio_rx #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .tick    (base_tick),
        .rx_en   (rx_enable),
        .par_en  (par_en),
        .rxd_i   (ser_in),
        .rd_ack  (rx_ack),
        .clr_ovr (clr_overrun),
        .clr_par (clr_parity),
        .clr_frm (clr_framing),
        .data_o  (rx_data),
        .full_o  (rx_full),
        .err_o   (rx_err)
    );

    sio_pinmux u_mux (
        .tx_en    (tx_enable),
        .tx_line  (tx_line),
        .port_dir (pin_dir),
        .port_lvl (pin_level),
        .pin_o    (ser_out),
        .pin_oe   (ser_oe)
    );

    assign err_overrun = rx_err.ovr;
    assign err_parity  = rx_err.par;
    assign err_framing = rx_err.frm;

endmodule

// File: rtl/sio_break_unit_chk.sv
module sio_break_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_enable,
    input logic              sync_mode,
    input logic              tx_write,
    input logic              tx_empty,
    input logic              rx_ack,
    input logic              rx_full,
    input logic [DATA_W-1:0] rx_data,
    input logic              clr_overrun,
    input logic              clr_parity,
    input logic              clr_framing,
    input logic              err_overrun,
    input logic              err_parity,
    input logic              err_framing
);
    // R3: a disabled transmitter has an empty holding register one cycle later
    a_r3_disable_empties: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |=> tx_empty);

    // R4: an accepted write fills the holding register
    a_r4_write_fills: assert property (@(posedge clk) disable iff (rst)
        (tx_enable && tx_empty && tx_write) |=> !tx_empty);

    // R7: clocked framing holds a stored byte while errors are pending
    a_r7_interlock: assert property (@(posedge clk) disable iff (rst)
        (tx_enable && sync_mode && (err_overrun || err_parity || err_framing) && !tx_empty)
        |=> !tx_empty);

    // R11: an unread byte is never replaced
    a_r11_keep_unread: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rx_ack) |=> (rx_full && $stable(rx_data)));

    // R12: flags persist until their own clear strobe
    a_r12_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_overrun && !clr_overrun) |=> err_overrun);
    a_r12_par_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_parity && !clr_parity) |=> err_parity);
    a_r12_frm_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_framing && !clr_framing) |=> err_framing);
endmodule

bind sio_break_unit sio_break_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sio_break_unit_tb.sv
module sio_break_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       base_tick;
    logic       tx_enable = 0, rx_enable = 0, sync_mode = 0, par_en = 0;
    logic       pin_dir = 0, pin_level = 0, tx_write = 0;
    logic [7:0] tx_data = 0;
    logic       ser_in = 1, rx_ack = 0;
    logic       clr_overrun = 0, clr_parity = 0, clr_framing = 0;
    logic       tx_empty, rx_full, err_overrun, err_parity, err_framing;
    logic       ser_out, ser_oe, ser_clk;
    logic [7:0] rx_data;

    always #2 clk = ~clk;

    sio_break_unit u_dut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // base tick: every second clock
    int dcnt = 0;
    always @(posedge clk) dcnt <= rst ? 0 : (dcnt == 1 ? 0 : dcnt + 1);
    assign base_tick = !rst && (dcnt == 0);

    // behavioural transmit reference, compared every clock
    bit       m_on = 0, m_full = 0, m_act = 0, m_err = 0;
    bit [7:0] m_hold;
    bit       m_q[$];
    int       m_ticks = 0;

    always @(posedge clk) begin
        bit full_pre;
        full_pre = m_full;
        if (rst || !tx_enable) begin
            m_full = 0; m_act = 0; m_ticks = 0; m_q.delete();
        end else begin
            if (m_act) begin
                if (base_tick) begin
                    if (m_ticks == 15) begin
                        m_ticks = 0;
                        void'(m_q.pop_front());
                        if (m_q.size() == 0) m_act = 0;
                    end else m_ticks++;
                end
            end else if (full_pre && !(sync_mode && m_err)) begin
                if (!sync_mode) m_q.push_back(1'b0);
                for (int i = 0; i < 8; i++) m_q.push_back(m_hold[i]);
                if (!sync_mode) begin
                    if (par_en) m_q.push_back(^m_hold);
                    m_q.push_back(1'b1);
                end
                m_act = 1; m_ticks = 0; m_full = 0;
            end
            if (tx_write && !full_pre) begin
                m_full = 1; m_hold = tx_data;
            end
        end
        #1;
        if (m_on) begin
            chk("R4 tx_empty", tx_empty, !m_full);
            if (tx_enable) begin
                chk("R2 ser_oe", ser_oe, 1);
                if (m_act) chk(sync_mode ? "R6 data bit" : "R5 frame bit", ser_out, m_q[0]);
                else       chk("R2 idle level", ser_out, 1);
                chk("R6 ser_clk", ser_clk, (m_act && sync_mode) ? (m_ticks >= 8) : 1);
            end else begin
                chk("R1 ser_oe", ser_oe, pin_dir);
                chk("R1 ser_out", ser_out, pin_level);
            end
        end
        m_err = err_overrun | err_parity | err_framing;
    end

    task automatic next_tick();
        @(negedge clk);
        while (!base_tick) @(negedge clk);
    endtask

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) begin next_tick(); ser_in = 1; end
    endtask

    // smear: every tick except the sample tick carries the inverted bit
    task automatic rx_frame(input logic [7:0] d, input bit with_par, input bit par_val,
                            input bit stop_val, input bit smear);
        bit b[$];
        b.push_back(1'b0);
        for (int i = 0; i < 8; i++) b.push_back(d[i]);
        if (with_par) b.push_back(par_val);
        b.push_back(stop_val);
        for (int j = 0; j < b.size() * 16; j++) begin
            bit v;
            int off;
            off = j % 16;
            v = b[j / 16];
            if (smear && off != 7 && j != 0 && !((j / 16) == b.size() - 1 && off > 7)) v = ~v;
            next_tick();
            ser_in = v;
        end
        idle_ticks(20);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1;
        @(negedge clk); s = 0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk); tx_data = d; tx_write = 1;
        @(negedge clk); tx_write = 0;
    endtask

    task automatic wait_tx_idle();
        @(negedge clk);
        while (m_act || m_full) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0; m_on = 1;
        @(negedge clk);
        chk("R4 reset tx_empty", tx_empty, 1);
        chk("R10 reset rx_full", rx_full, 0);
        chk("R12 reset flags", {err_overrun, err_parity, err_framing}, 0);
        chk("R1 reset ser_oe", ser_oe, 0);

        // R1: fallback pin
        pin_dir = 1; pin_level = 1;
        repeat (3) @(negedge clk);
        chk("R1 fallback high", {ser_oe, ser_out}, 2'b11);
        pin_level = 0;
        @(negedge clk);
        chk("R1 fallback low", {ser_oe, ser_out}, 2'b10);
        pin_level = 1;

        // R5: asynchronous frames, without and with parity, back to back
        tx_enable = 1;
        send_byte(8'hA5);
        wait_tx_idle();
        par_en = 1;
        send_byte(8'h3C);
        send_byte(8'h81);
        wait_tx_idle();
        par_en = 0;

        // R3: break in the middle of a frame
        send_byte(8'h00);
        repeat (100) @(negedge clk);
        pin_level = 0;
        @(negedge clk);
        tx_enable = 0;
        @(negedge clk);
        chk("R3 tx_empty after abort", tx_empty, 1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk("R3 break level", {ser_oe, ser_out}, 2'b10);
        end
        pin_level = 1;
        tx_enable = 1;
        repeat (40) @(negedge clk);
        chk("R3 transmitter idle after re-enable", ser_out, 1);

        // R8: exact sample tick
        rx_enable = 1;
        rx_frame(8'h5A, 0, 0, 1, 1);
        chk("R8 rx_full", rx_full, 1);
        chk("R8 rx_data", rx_data, 8'h5A);
        chk("R8 no flags", {err_overrun, err_parity, err_framing}, 0);
        pulse(rx_ack);
        chk("R11 ack clears full", rx_full, 0);

        // R9: false start
        for (int j = 0; j < 7; j++) begin next_tick(); ser_in = 0; end
        idle_ticks(40);
        chk("R9 false start stores nothing", rx_full, 0);
        chk("R9 false start no flags", {err_overrun, err_parity, err_framing}, 0);
        rx_frame(8'hC3, 0, 0, 1, 1);
        chk("R9 next frame data", rx_data, 8'hC3);
        pulse(rx_ack);

        // R10: parity and framing errors
        par_en = 1;
        rx_frame(8'h0F, 1, 1, 1, 0);
        chk("R10 parity flag", err_parity, 1);
        chk("R10 data kept on parity error", rx_data, 8'h0F);
        pulse(rx_ack);
        rx_frame(8'h6B, 1, 1, 1, 0);
        chk("R10 good parity stored", rx_data, 8'h6B);
        pulse(rx_ack);
        par_en = 0;
        rx_frame(8'h77, 0, 0, 0, 0);
        chk("R10 framing flag", err_framing, 1);
        pulse(rx_ack);

        // R12: sticky through receiver disable
        rx_enable = 0;
        repeat (10) @(negedge clk);
        chk("R12 flags kept", {err_parity, err_framing}, 2'b11);
        pulse(clr_parity);
        chk("R12 parity cleared alone", {err_parity, err_framing}, 2'b01);
        pulse(clr_framing);
        chk("R12 framing cleared", err_framing, 0);

        // R11: overrun
        rx_enable = 1;
        rx_frame(8'h11, 0, 0, 1, 0);
        rx_frame(8'h22, 0, 0, 1, 0);
        chk("R11 overrun flag", err_overrun, 1);
        chk("R11 unread byte kept", rx_data, 8'h11);
        pulse(rx_ack);

        // R7: interlock in clocked framing, then R6 frame
        sync_mode = 1;
        send_byte(8'h96);
        repeat (120) @(negedge clk);
        chk("R7 held while error pending", tx_empty, 0);
        chk("R7 line idle while held", ser_out, 1);
        pulse(clr_overrun);
        repeat (3) @(negedge clk);
        chk("R7 starts after clear", tx_empty, 1);
        wait_tx_idle();
        sync_mode = 0;

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule